// File: doc/BRIEF.md
# Banked Register File Decoder

This block turns a file-register access from the core into a target: one of fifteen special registers, one byte of a 68-byte general-purpose RAM, or nothing. A direct access gives a 7-bit field from the instruction. The current bank bit goes on top of that field to form an 8-bit address, so bank 0 covers 00h-7Fh and bank 1 covers 80h-FFh. A direct field of zero names the indirect pseudo-register. In that case all 8 bits of the pointer register form the address, and the bank bit plays no part.

Five core registers sit at the same offset in both banks. Five further offsets hold different registers in each bank. The RAM occupies offsets 0Ch-4Fh and appears identically in both banks. Holes read back as zero and take no writes. The RAM lives inside the block. The special registers stay outside it: the block gives each one a select strobe and a write strobe, and takes its read value from a flat bus.

Top module: `banked_file_decoder`

## Requirements
- R1: A direct access (dir_field not 0) targets address {bank_bit, dir_field}: bank_bit 0 reaches 00h-7Fh and bank_bit 1 reaches 80h-FFh.
- R2: When dir_field is 0 and the low 7 pointer bits are not all zero, the access targets the address held in ptr_reg[7:0]. bank_bit is ignored.
- R3: Offsets 02h, 03h, 04h, 0Ah and 0Bh select strobe bits 0, 1, 2, 3 and 4 in either bank.
- R4: Offsets 01h, 05h, 06h, 08h and 09h select strobe bits 5, 6, 7, 8 and 9 in bank 0, and bits 10, 11, 12, 13 and 14 in bank 1.
- R5: Offsets 0Ch-4Fh reach RAM byte (offset - 0Ch) in either bank. A byte written through one bank reads back through the other.
- R6: Offsets 07h and 50h-7Fh in either bank read as 0. Writes to them raise no strobe and change no RAM byte.
- R7: An indirect access whose pointer is 00h or 80h reads 0. Its write raises no strobe and changes nothing.
- R8: At most one sfr_sel bit is high, and only while rd_en or wr_en is high. sfr_we is high only with a write to a special register. A special-register read returns sfr_rdata[8k+7:8k] for strobe bit k. rd_data is 0 while rd_en is low.
- R9: After reset every RAM byte reads 0.
- R10: A RAM write takes effect at the rising clock edge. A read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| dir_field | input | 7 | Address field from the instruction; 0 selects indirect |
| bank_bit | input | 1 | Bank select for direct accesses |
| ptr_reg | input | 8 | Current pointer register value |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| sfr_sel | output | 15 | One-hot special register select |
| sfr_we | output | 1 | Write strobe for the selected special register |
| sfr_rdata | input | 120 | Read values of the special registers, slot k at [8k+7:8k] |

## Verification
The bench writes RAM through one bank and reads it back through the other. A decoder that let the bank bit split the RAM would then return stale data. Indirect accesses are given pointers whose top bit disagrees with bank_bit, which exposes a design that mixes the bank bit into the indirect address. The pointer values 00h and 80h are driven on reads and on writes. A design that recursed there, or aliased 00h onto RAM, would return nonzero data or corrupt a byte. Offset 07h, the 50h-7Fh range and boundary offsets 0Bh, 0Ch, 4Fh and 50h are probed. An off-by-one range check would show up as a strobe or a stray RAM write there.

// File: rtl/rfd_pkg.sv
// Shared types and slot numbering for the banked register file decoder.
// Assumes an 8-bit file address whose top bit is the bank.
package rfd_pkg;

    // Kind of target an access resolves to
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_SFR  = 2'd1,
        RG_RAM  = 2'd2
    } region_e;

    localparam int SLOT_COUNT = 15;
    localparam int SLOT_W     = 4;

    // Strobe bit numbering; shared registers first
    localparam logic [SLOT_W-1:0] SL_PCLO   = 4'd0;
    localparam logic [SLOT_W-1:0] SL_STAT   = 4'd1;
    localparam logic [SLOT_W-1:0] SL_PTR    = 4'd2;
    localparam logic [SLOT_W-1:0] SL_PCHI   = 4'd3;
    localparam logic [SLOT_W-1:0] SL_IRQC   = 4'd4;
    localparam logic [SLOT_W-1:0] SL_TIMER  = 4'd5;
    localparam logic [SLOT_W-1:0] SL_PORTA  = 4'd6;
    localparam logic [SLOT_W-1:0] SL_PORTB  = 4'd7;
    localparam logic [SLOT_W-1:0] SL_NVDATA = 4'd8;
    localparam logic [SLOT_W-1:0] SL_NVADDR = 4'd9;
    localparam logic [SLOT_W-1:0] SL_CONFIG = 4'd10;
    localparam logic [SLOT_W-1:0] SL_DIRA   = 4'd11;
    localparam logic [SLOT_W-1:0] SL_DIRB   = 4'd12;
    localparam logic [SLOT_W-1:0] SL_NVCTL  = 4'd13;
    localparam logic [SLOT_W-1:0] SL_NVKEY  = 4'd14;

endpackage

// File: rtl/rfd_addr_resolve.sv
// Forms the effective file address from a direct field plus bank bit,
// or from the pointer register when the field names the indirect slot.
// Assumes the indirect slot is offset 0 and the pointer is ADDR_W wide.
module rfd_addr_resolve #(
    parameter int FIELD_W = 7,
    parameter int ADDR_W  = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] dir_field,
    input  logic               bank_bit,
    input  logic [ADDR_W-1:0]  ptr_reg,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic               is_null
);

    logic is_ind;

    // Choose between the direct and the indirect address source
    always_comb begin
        is_ind   = (dir_field == '0);
        eff_addr = is_ind ? ptr_reg : {bank_bit, dir_field};
        is_null  = is_ind && (ptr_reg[FIELD_W-1:0] == '0);
    end

endmodule

// File: rtl/rfd_region_decode.sv
// Classifies an effective address as special register, RAM byte or hole.
// Assumes the special span starts at offset 0 and RAM follows at RAM_BASE.
module rfd_region_decode
    import rfd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RAM_BASE  = 12,
    parameter int RAM_BYTES = 68,
    parameter int IDX_W     = $clog2(RAM_BYTES)
) (
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              is_null,
    output region_e           region,
    output logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  ram_idx
);

    localparam int OFF_W = ADDR_W - 1;
    localparam logic [OFF_W-1:0] RAM_LO = OFF_W'(RAM_BASE);
    localparam logic [OFF_W-1:0] RAM_HI = OFF_W'(RAM_BASE + RAM_BYTES);

    logic [OFF_W-1:0] offset;
    logic             bank;
    logic [OFF_W-1:0] rel;

    assign offset = eff_addr[OFF_W-1:0];
    assign bank   = eff_addr[ADDR_W-1];
    assign rel    = offset - RAM_LO;

    // Map offset and bank onto a target kind and index
    always_comb begin
        region  = RG_NONE;
        slot    = '0;
        ram_idx = rel[IDX_W-1:0];
        if (!is_null) begin
            if (offset >= RAM_LO && offset < RAM_HI) begin
                region = RG_RAM;
            end else begin
                region = RG_SFR;
                case (offset)
                    7'h01:   slot = bank ? SL_CONFIG : SL_TIMER;
                    7'h02:   slot = SL_PCLO;
                    7'h03:   slot = SL_STAT;
                    7'h04:   slot = SL_PTR;
                    7'h05:   slot = bank ? SL_DIRA : SL_PORTA;
                    7'h06:   slot = bank ? SL_DIRB : SL_PORTB;
                    7'h08:   slot = bank ? SL_NVCTL : SL_NVDATA;
                    7'h09:   slot = bank ? SL_NVKEY : SL_NVADDR;
                    7'h0A:   slot = SL_PCHI;
                    7'h0B:   slot = SL_IRQC;
                    default: region = RG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rfd_gpr_ram.sv
// General-purpose byte store shared by both banks.
// Assumes one write port, one combinational read port, clear on reset.
module rfd_gpr_ram #(
    parameter int DEPTH  = 68,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_byte
            // Hold one byte, cleared on reset, loaded when addressed
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (we && idx == IDX_W'(i))
                    mem[i] <= wdata;
            end
        end
    endgenerate

    // Return the addressed byte, zero past the end
    always_comb begin
        rdata = '0;
        for (int j = 0; j < DEPTH; j++)
            if (idx == IDX_W'(j))
                rdata = mem[j];
    end

endmodule

// File: rtl/rfd_sfr_port.sv
// Drives the one-hot select and write strobe toward the special registers
// and picks the selected register's read value.
// Assumes slot is meaningful only when region is RG_SFR.
module rfd_sfr_port
    import rfd_pkg::*;
#(
    parameter int SLOTS  = SLOT_COUNT,
    parameter int DATA_W = 8
) (
    input  logic                    access,
    input  logic                    is_write,
    input  region_e                 region,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [SLOTS*DATA_W-1:0] sfr_rdata,
    output logic [SLOTS-1:0]        sfr_sel,
    output logic                    sfr_we,
    output logic [DATA_W-1:0]       rdata
);

    logic              hit;
    logic [DATA_W-1:0] part [SLOTS];

    assign hit = access && (region == RG_SFR);

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign sfr_sel[k] = hit && (slot == SLOT_W'(k));
            assign part[k]    = sfr_sel[k] ? sfr_rdata[k*DATA_W +: DATA_W] : '0;
        end
    endgenerate

    // Merge the masked register values into one read word
    always_comb begin
        rdata = '0;
        for (int k = 0; k < SLOTS; k++)
            rdata = rdata | part[k];
    end

    assign sfr_we = hit && is_write;

endmodule

// File: rtl/banked_file_decoder.sv
// Top of the banked register file decoder: resolves the address, decodes
// the region, holds the shared RAM and strobes the special registers.
// Assumes read and write in one cycle see the pre-write RAM value.
module banked_file_decoder
    import rfd_pkg::*;
#(
    parameter int FIELD_W   = 7,
    parameter int DATA_W    = 8,
    parameter int RAM_BASE  = 12,
    parameter int RAM_BYTES = 68,
    parameter int SLOTS     = SLOT_COUNT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [FIELD_W-1:0]      dir_field,
    input  logic                    bank_bit,
    input  logic [FIELD_W:0]        ptr_reg,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       rd_data,
    output logic [SLOTS-1:0]        sfr_sel,
    output logic                    sfr_we,
    input  logic [SLOTS*DATA_W-1:0] sfr_rdata
);

    localparam int ADDR_W = FIELD_W + 1;
    localparam int IDX_W  = $clog2(RAM_BYTES);

    logic [ADDR_W-1:0] eff_addr;
    logic              is_null;
    region_e           region;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  ram_idx;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] sfr_rd;
    logic              ram_we;

    rfd_addr_resolve #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_res (
        .dir_field (dir_field),
        .bank_bit  (bank_bit),
        .ptr_reg   (ptr_reg),
        .eff_addr  (eff_addr),
        .is_null   (is_null)
    );

    rfd_region_decode #(
        .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE),
        .RAM_BYTES(RAM_BYTES), .IDX_W(IDX_W)
    ) u_dec (
        .eff_addr (eff_addr),
        .is_null  (is_null),
        .region   (region),
        .slot     (slot),
        .ram_idx  (ram_idx)
    );

    assign ram_we = wr_en && (region == RG_RAM);

    rfd_gpr_ram #(.DEPTH(RAM_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wr_data),
        .rdata (ram_rd)
    );

    rfd_sfr_port #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_sfr (
        .access    (rd_en || wr_en),
        .is_write  (wr_en),
        .region    (region),
        .slot      (slot),
        .sfr_rdata (sfr_rdata),
        .sfr_sel   (sfr_sel),
        .sfr_we    (sfr_we),
        .rdata     (sfr_rd)
    );

    // Steer read data from the resolved target; holes and idle give zero
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (region)
                RG_RAM:  rd_data = ram_rd;
                RG_SFR:  rd_data = sfr_rd;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/rfd_checker.sv
// Property checker for banked_file_decoder, attached with bind.
// Assumes default parameters: 7-bit field, 15 slots, RAM at 0Ch-4Fh.
module rfd_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_en,
    input logic         wr_en,
    input logic [6:0]   dir_field,
    input logic         bank_bit,
    input logic [7:0]   ptr_reg,
    input logic [7:0]   wr_data,
    input logic [7:0]   rd_data,
    input logic [14:0]  sfr_sel,
    input logic         sfr_we,
    input logic [119:0] sfr_rdata
);

    logic dir_ram;
    assign dir_ram = (dir_field >= 7'h0C) && (dir_field <= 7'h4F);

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sfr_sel));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> (sfr_sel == '0 && !sfr_we && rd_data == '0));

    a_r6_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_field == 7'h07 || dir_field >= 7'h50) |-> (sfr_sel == '0 && rd_data == '0));

    a_r7_self: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_field == '0 && ptr_reg[6:0] == '0) |-> (sfr_sel == '0 && !sfr_we && rd_data == '0));

    a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dir_field == 7'h03) |-> (sfr_sel == 15'h0002));

    a_r5_alias: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(dir_ram) && rd_en && !wr_en
         && dir_field == $past(dir_field)) |-> (rd_data == $past(wr_data)));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && rd_en && dir_ram) |-> (rd_data == '0));

endmodule

bind banked_file_decoder rfd_checker u_chk (.*);

// File: tb/banked_file_decoder_test.sv
// Self-checking bench: directed corners then seeded random accesses,
// compared against a reference decode and a RAM model.
module banked_file_decoder_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0, wr_en = 1'b0, bank_bit = 1'b0;
    logic [6:0]   dir_field = '0;
    logic [7:0]   ptr_reg = '0, wr_data = '0;
    logic [7:0]   rd_data;
    logic [14:0]  sfr_sel;
    logic         sfr_we;
    logic [119:0] sfr_rdata = '0;

    int n_checks = 0, n_fail = 0;
    logic [7:0] mdl [68];

    always #4 clk = ~clk;

    banked_file_decoder uut (.*);

    // Reference: -1 zero target, 0..14 strobe bit, 100+n RAM byte n
    function automatic int ref_key(input logic [6:0] f, input logic b, input logic [7:0] p);
        logic [7:0] a;
        if (f == 7'd0) begin
            if (p[6:0] == 7'd0) return -1;
            a = p;
        end else a = {b, f};
        case (a[6:0])
            7'h01: return a[7] ? 10 : 5;
            7'h02: return 0;
            7'h03: return 1;
            7'h04: return 2;
            7'h05: return a[7] ? 11 : 6;
            7'h06: return a[7] ? 12 : 7;
            7'h08: return a[7] ? 13 : 8;
            7'h09: return a[7] ? 14 : 9;
            7'h0A: return 3;
            7'h0B: return 4;
            default: if (a[6:0] >= 7'h0C && a[6:0] <= 7'h4F) return 100 + int'(a[6:0]) - 12;
        endcase
        return -1;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: drive at falling edge, check mid-cycle, model the write
    task automatic do_op(input logic [6:0] f, input logic b, input logic [7:0] p,
                         input logic rd, input logic wr, input logic [7:0] wd, input string tag);
        int key;
        string req;
        logic [7:0] exp_rd;
        logic [14:0] exp_sel;
        @(negedge clk);
        dir_field = f; bank_bit = b; ptr_reg = p; rd_en = rd; wr_en = wr; wr_data = wd;
        for (int k = 0; k < 15; k++) sfr_rdata[k*8 +: 8] = 8'($urandom);
        key = ref_key(f, b, p);
        if (tag != "") req = tag;
        else if (!rd && !wr) req = "R8";
        else if (f == 0) req = (p[6:0] == 0) ? "R7" : "R2";
        else if (key >= 100) req = "R5";
        else if (key >= 5) req = "R4";
        else if (key >= 0) req = "R3";
        else req = "R6";
        exp_sel = '0; exp_rd = '0;
        if ((rd || wr) && key >= 0 && key < 15) exp_sel = 15'(1 << key);
        if (rd) begin
            if (key >= 100) exp_rd = mdl[key - 100];
            else if (key >= 0) exp_rd = sfr_rdata[key*8 +: 8];
        end
        #2;
        check(req, "rd_data", 32'(rd_data), 32'(exp_rd));
        check(req, "sfr_sel", 32'(sfr_sel), 32'(exp_sel));
        check(req, "sfr_we", 32'(sfr_we), 32'(wr && key >= 0 && key < 15));
        if (wr && key >= 100) mdl[key - 100] = wd;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 68; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: cleared RAM at both ends and through an indirect pointer
        do_op(7'h0C, 0, 8'h00, 1, 0, 0, "R9");
        do_op(7'h4F, 1, 8'h00, 1, 0, 0, "R9");
        do_op(7'h00, 0, 8'hA0, 1, 0, 0, "R9");
        // R5: write bank 0, read bank 1; R10 same-cycle read sees old value
        do_op(7'h0C, 0, 8'h00, 0, 1, 8'h5A, "R5");
        do_op(7'h0C, 1, 8'h00, 1, 0, 0, "R5");
        do_op(7'h4F, 1, 8'h00, 1, 1, 8'hC3, "R10");
        do_op(7'h4F, 0, 8'h00, 1, 0, 0, "R10");
        // R1: bank bit picks the register at a banked offset
        do_op(7'h01, 0, 8'h00, 1, 0, 0, "R1");
        do_op(7'h01, 1, 8'h00, 1, 0, 0, "R1");
        // R2: pointer top bit against bank bit
        do_op(7'h00, 0, 8'h85, 1, 0, 0, "R2");
        do_op(7'h00, 1, 8'h06, 1, 1, 8'h11, "R2");
        do_op(7'h00, 1, 8'h3C, 0, 1, 8'h77, "R2");
        do_op(7'h3C, 1, 8'h00, 1, 0, 0, "R2");
        // R7: self-referencing pointer
        do_op(7'h00, 0, 8'h00, 1, 1, 8'hFF, "R7");
        do_op(7'h00, 1, 8'h80, 1, 1, 8'hEE, "R7");
        // R6: holes and range edges, then verify RAM untouched
        do_op(7'h07, 0, 8'h00, 1, 1, 8'h99, "R6");
        do_op(7'h07, 1, 8'h00, 1, 1, 8'h99, "R6");
        do_op(7'h50, 0, 8'h00, 1, 1, 8'h98, "R6");
        do_op(7'h7F, 1, 8'h00, 1, 1, 8'h97, "R6");
        do_op(7'h00, 0, 8'hD0, 1, 1, 8'h96, "R6");
        do_op(7'h0B, 1, 8'h00, 1, 0, 0, "R3");
        for (int o = 12; o < 80; o++) do_op(7'(o), o[0], 8'h00, 1, 0, 0, "R6");
        // R3/R4: every special offset in both banks
        for (int o = 1; o < 12; o++) begin
            do_op(7'(o), 0, 8'h00, 1, 1, 8'(o), "");
            do_op(7'(o), 1, 8'h00, 1, 0, 0, "");
        end
        do_op(7'h03, 1, 8'h00, 0, 0, 0, "R8");
        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] f;
            logic [7:0] p;
            f = 7'($urandom);
            if ($urandom_range(3) == 0) f = '0;
            p = 8'($urandom);
            if ($urandom_range(15) == 0) p = {p[7], 7'd0};
            do_op(f, 1'($urandom), p, 1'($urandom), 1'($urandom), 8'($urandom), "");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule